// File: doc/BRIEF.md
# Up-counting timer channel with three compare registers

This block is one timer channel. It counts up on a tick enable that the block selects from its own clock. Two compare registers raise alarm flags when the count reaches their value. A third compare register sets the top value. When the count equals that top, the next tick returns it to zero and a top flag is raised. A top value of zero means no top: the counter runs to its all-ones value and wraps.

Software drives the block through a small register port. The port has these registers:
- a control register with start, stop and restart strobes
- a count readback
- the three compare values
- a status register that clears on read
- write-1 set and write-1 clear registers for the interrupt mask, plus a mask readback
- a mode register that selects the tick source

One level interrupt output goes high while any flag is set and its mask bit is also set.

The tick source is one of three kinds. Four sources are internal divisions of the main clock. One is a slow tick strobe. Three are external tick strobes. All strobes are synchronous to the main clock. A no-divide mode counts on every clock instead.

Top module: `tmr_channel`

## Requirements
- R1: A control write (address 0) with bit 0 and bit 2 set enables counting and loads the count with zero. A control write with bit 1 set disables counting; bit 1 wins over bit 0. While disabled, the count holds its value.
- R2: A control write with only bit 2 set loads the count with zero and leaves the enable state unchanged.
- R3: When top (address 5) is non-zero and the count equals top, the next tick loads zero. The tick that brings the count to top sets status bit 2.
- R4: When top is zero, the count runs to the all-ones value of its width and then wraps to zero. Status bit 2 is never set in this case.
- R5: The tick that brings the count to the value of compare A (address 3) sets status bit 0. The tick that brings it to compare B (address 4) sets status bit 1.
- R6: A read of status (address 6) returns the flags and clears them. A flag set in the same cycle as that read is kept.
- R7: Writing ones to address 7 sets those mask bits. Writing ones to address 8 clears them. The mask reads back at address 9, with bit positions equal to the status bits.
- R8: irq_o is high exactly when some status bit and the same mask bit are both set.
- R9: Mode bits [2:0] (address 1) select the tick source: 0, 1, 2 and 3 give one tick in 2, 8, 32 and 128 clocks; 4 gives slow_tick_i; 5, 6 and 7 give ext_tick_i[0], [1] and [2]. Mode bit 3 set ticks on every clock.
- R10: Compare values and the count are CNT_W bits wide, and upper write bits are dropped. After reset the count, status, mask and irq_o are all zero. The count readback is at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of req_i |
| slow_tick_i | input | 1 | Slow tick strobe, one clock wide |
| ext_tick_i | input | 3 | External tick strobes, one clock wide each |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter is tried against several tick sources:
- The every-clock source gives an exact value one cycle after each start.
- Hand-pulsed slow and external strobes show that only the selected strobe advances the count.
- The divide-by-8 source over a 48-clock window shows the prescaler division.

A short top of 4 with compares at 2 and 3 shows the wrap sequence and all three flags. A top of zero runs the full 16-bit range, which tells the free-running wrap apart from a top compare. Back-to-back status reads around the cycle where compare A is reached show that a flag set during a clearing read survives.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 4;
  localparam int NUM_FLAGS = 3;
  localparam int NUM_CMP   = 2;
  localparam int NUM_DIV   = 4;
  localparam int NUM_EXT   = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 4'd0,
    REG_MODE   = 4'd1,
    REG_VALUE  = 4'd2,
    REG_CMPA   = 4'd3,
    REG_CMPB   = 4'd4,
    REG_TOP    = 4'd5,
    REG_STATUS = 4'd6,
    REG_IEN    = 4'd7,
    REG_IDIS   = 4'd8,
    REG_IMASK  = 4'd9
  } reg_addr_e;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_DIS   = 1;
  localparam int CTRL_TRG   = 2;
  localparam int MODE_SEL_W = 3;
  localparam int MODE_NODIV = 3;
  localparam int FLG_A      = 0;
  localparam int FLG_B      = 1;
  localparam int FLG_C      = 2;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int NUM_DIV = 4,
  parameter int NUM_EXT = 3,
  localparam int SRC_N  = NUM_DIV + 1 + NUM_EXT,
  localparam int SEL_W  = $clog2(SRC_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               nodiv_i,
  input  logic               slow_tick_i,
  input  logic [NUM_EXT-1:0] ext_tick_i,
  output logic               tick_o
);
  localparam int PRE_W = 2 * NUM_DIV - 1;

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] div_tick;
  logic [SRC_N-1:0]   src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  // divider g ticks once every 2^(2g+1) clocks
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    assign div_tick[g] = &pre_q[2*g:0];
  end

  assign src    = {ext_tick_i, slow_tick_i, div_tick};
  assign tick_o = nodiv_i | src[sel_i];
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           run_i,
  input  logic                           clr_i,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_i,
  input  logic [CNT_W-1:0]               top_i,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [NUM_CMP-1:0]             hit_cmp_o,
  output logic                           hit_top_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, nxt, top_eff;
  logic             step;

  assign top_eff = (top_i == '0) ? CNT_MAX : top_i;
  assign nxt     = (cnt_q == top_eff) ? '0 : cnt_q + 1'b1;
  assign step    = run_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= nxt;
  end

  // events flag on the tick that lands on the compare value
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign hit_cmp_o[g] = step && (nxt == cmp_i[g]);
  end
  assign hit_top_o = step && (top_i != '0) && (nxt == top_i);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              slow_tick_i,
  input  logic [NUM_EXT-1:0] ext_tick_i,
  output logic              irq_o
);
  logic                           en_q, nodiv_q, tick, run, trg;
  logic [MODE_SEL_W-1:0]          sel_q;
  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]               top_q, cnt;
  logic [NUM_FLAGS-1:0]           status_q, mask_q, hit, clr_mask;
  logic [NUM_CMP-1:0]             hit_cmp;
  logic                           hit_top;
  logic                           wr, rd, wr_ctrl;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign wr_ctrl = wr && (addr_i == REG_CTRL);
  assign trg     = wr_ctrl && wdata_i[CTRL_TRG];
  assign run     = en_q && tick;

  tmr_tick_sel #(.NUM_DIV(NUM_DIV), .NUM_EXT(NUM_EXT)) i_tick (
    .clk_i, .rst_ni,
    .sel_i(sel_q), .nodiv_i(nodiv_q),
    .slow_tick_i, .ext_tick_i,
    .tick_o(tick)
  );

  tmr_count #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) i_count (
    .clk_i, .rst_ni,
    .run_i(run), .clr_i(trg),
    .cmp_i(cmp_q), .top_i(top_q),
    .cnt_o(cnt), .hit_cmp_o(hit_cmp), .hit_top_o(hit_top)
  );

  assign hit      = {hit_top, hit_cmp};
  assign clr_mask = (rd && addr_i == REG_STATUS) ? '1 : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      nodiv_q  <= 1'b0;
      sel_q    <= '0;
      cmp_q    <= '0;
      top_q    <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | hit;
      if (wr_ctrl) begin
        if (wdata_i[CTRL_DIS])     en_q <= 1'b0;
        else if (wdata_i[CTRL_EN]) en_q <= 1'b1;
      end
      if (wr) begin
        case (addr_i)
          REG_MODE: begin
            sel_q   <= wdata_i[MODE_SEL_W-1:0];
            nodiv_q <= wdata_i[MODE_NODIV];
          end
          REG_CMPA: cmp_q[0] <= wdata_i[CNT_W-1:0];
          REG_CMPB: cmp_q[1] <= wdata_i[CNT_W-1:0];
          REG_TOP:  top_q    <= wdata_i[CNT_W-1:0];
          REG_IEN:  mask_q   <= mask_q | wdata_i[NUM_FLAGS-1:0];
          REG_IDIS: mask_q   <= mask_q & ~wdata_i[NUM_FLAGS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        REG_MODE:   rdata_o = BUS_W'({nodiv_q, sel_q});
        REG_VALUE:  rdata_o = BUS_W'(cnt);
        REG_CMPA:   rdata_o = BUS_W'(cmp_q[0]);
        REG_CMPB:   rdata_o = BUS_W'(cmp_q[1]);
        REG_TOP:    rdata_o = BUS_W'(top_q);
        REG_STATUS: rdata_o = BUS_W'(status_q);
        REG_IMASK:  rdata_o = BUS_W'(mask_q);
        default:    rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(status_q & mask_q);
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [BUS_W-1:0]     wdata_i,
  input logic                 irq_o,
  input logic [CNT_W-1:0]     cnt,
  input logic [CNT_W-1:0]     top_q,
  input logic                 run,
  input logic                 trg,
  input logic [NUM_FLAGS-1:0] hit,
  input logic [NUM_FLAGS-1:0] status_q,
  input logic [NUM_FLAGS-1:0] mask_q
);
  assert_hold_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !trg) |=> $stable(cnt));

  assert_wrap_at_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !trg && top_q != '0 && cnt == top_q) |=> (cnt == '0));

  assert_clear_on_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == REG_STATUS && hit == '0) |=> (status_q == '0));

  assert_mask_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == REG_IEN) |=>
      ((mask_q & $past(wdata_i[NUM_FLAGS-1:0])) == $past(wdata_i[NUM_FLAGS-1:0])));

  assert_mask_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == REG_IDIS) |=>
      ((mask_q & $past(wdata_i[NUM_FLAGS-1:0])) == '0));

  assert_irq_needs_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0 && status_q != '0));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .cnt(cnt), .top_q(top_q), .run(run), .trg(trg), .hit(hit),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        slow = 1'b0;
  logic [2:0]  ext = '0;
  logic        irq;
  int          nchk = 0, nerr = 0;

  localparam logic [3:0] A_CTRL = 0, A_MODE = 1, A_VAL = 2, A_CMPA = 3, A_CMPB = 4,
                         A_TOP = 5, A_STAT = 6, A_IEN = 7, A_IDIS = 8, A_MASK = 9;
  localparam logic [31:0] C_START = 5, C_STOP = 2, C_TRG = 4, M_NODIV = 8;

  tmr_channel #(.CNT_W(16)) i_tmr_channel (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .slow_tick_i(slow), .ext_tick_i(ext),
    .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #5 d = rdata;
    @(posedge clk); #1 req = 0;
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    if (src < 0) slow = 1; else ext[src] = 1;
    @(posedge clk); #1 slow = 0; ext = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #4 chk("R10 irq after reset", 32'(irq), 0);
    rd(A_VAL, v);  chk("R10 count after reset", v, 0);
    rd(A_STAT, v); chk("R10 status after reset", v, 0);
    rd(A_MASK, v); chk("R10 mask after reset", v, 0);
    wr(A_TOP, 32'h0001_2345);
    rd(A_TOP, v);  chk("R10 top truncated", v, 32'h2345);
    wr(A_TOP, 0);
  endtask

  task automatic t_start_stop();
    logic [31:0] v1, v2;
    wr(A_MODE, M_NODIV);
    wr(A_CTRL, C_START);
    rd(A_VAL, v1); chk("R1 start from zero", v1, 0);
    rd(A_VAL, v2); chk("R9 nodiv counts every clock", v2, 1);
    wr(A_CTRL, C_STOP);
    rd(A_VAL, v1); rd(A_VAL, v2); chk("R1 stopped holds", v2, v1);
    wr(A_CTRL, 3);
    rd(A_VAL, v2); chk("R1 disable wins over enable", v2, v1);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr(A_MODE, 4);
    wr(A_CTRL, C_START);
    pulse(-1); pulse(-1); pulse(-1);
    rd(A_VAL, v); chk("R9 slow tick source", v, 3);
    wr(A_CTRL, C_TRG);
    rd(A_VAL, v); chk("R2 trigger reloads zero", v, 0);
    pulse(-1);
    rd(A_VAL, v); chk("R2 trigger keeps enabled", v, 1);
    wr(A_MODE, 6);
    pulse(0);
    rd(A_VAL, v); chk("R9 unselected ext ignored", v, 1);
    pulse(1);
    rd(A_VAL, v); chk("R9 ext source 1", v, 2);
    wr(A_CTRL, C_STOP);
    wr(A_CTRL, C_TRG);
    pulse(1);
    rd(A_VAL, v); chk("R2 trigger keeps disabled", v, 0);
  endtask

  task automatic t_div8();
    logic [31:0] v, prev;
    bit ok;
    ok = 1; prev = 0;
    wr(A_MODE, 1);
    wr(A_CTRL, C_START);
    for (int i = 0; i <= 48; i++) begin
      rd(A_VAL, v);
      if (v < prev || v > prev + 1) ok = 0;
      prev = v;
    end
    chk("R9 div8 steps by one", 32'(ok), 1);
    chk("R9 div8 ticks in 48 clocks", v, 6);
    wr(A_CTRL, C_STOP);
  endtask

  task automatic t_wrap();
    logic [31:0] v, prev;
    bit ok;
    ok = 1;
    wr(A_MODE, M_NODIV);
    wr(A_CMPA, 2); wr(A_CMPB, 3); wr(A_TOP, 4);
    rd(A_STAT, v);
    wr(A_CTRL, C_START);
    rd(A_VAL, prev); chk("R3 first value", prev, 0);
    for (int i = 0; i < 14; i++) begin
      rd(A_VAL, v);
      if (v !== ((prev == 4) ? 0 : prev + 1)) ok = 0;
      prev = v;
    end
    chk("R3 wrap sequence at top", 32'(ok), 1);
    wr(A_CTRL, C_STOP);
    rd(A_STAT, v); chk("R5 R3 all three flags", v, 7);
    rd(A_STAT, v); chk("R6 status cleared by read", v, 0);
  endtask

  task automatic t_keep();
    logic [31:0] v;
    wr(A_CMPA, 5); wr(A_CMPB, 16'h7FFF); wr(A_TOP, 0);
    rd(A_STAT, v);
    wr(A_CTRL, C_START);
    for (int i = 1; i <= 5; i++) begin
      rd(A_STAT, v); chk("R5 no early compare flag", v, 0);
    end
    rd(A_STAT, v); chk("R6 flag set during read kept", v, 1);
    wr(A_CTRL, C_STOP);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    rd(A_STAT, v);
    wr(A_IEN, 1);  rd(A_MASK, v); chk("R7 set bit 0", v, 1);
    #4 chk("R8 no flag no irq", 32'(irq), 0);
    wr(A_IEN, 4);  rd(A_MASK, v); chk("R7 set bit 2", v, 5);
    wr(A_IDIS, 1); rd(A_MASK, v); chk("R7 clear bit 0", v, 4);
    wr(A_CMPA, 3);
    wr(A_CTRL, C_START);
    for (int i = 0; i < 6; i++) rd(A_VAL, v);
    wr(A_CTRL, C_STOP);
    #4 chk("R8 flag masked off", 32'(irq), 0);
    wr(A_IEN, 1);
    #4 chk("R8 flag enabled raises irq", 32'(irq), 1);
    wr(A_IDIS, 1);
    #4 chk("R8 disable drops irq", 32'(irq), 0);
    wr(A_IEN, 1);
    rd(A_STAT, v); chk("R6 read returns flag A", v, 1);
    #4 chk("R8 irq low after status read", 32'(irq), 0);
  endtask

  task automatic t_freerun();
    logic [31:0] v, prev;
    bit seen;
    seen = 0; prev = 0;
    wr(A_MODE, M_NODIV); wr(A_TOP, 0);
    rd(A_STAT, v);
    wr(A_CTRL, C_START);
    for (int i = 0; i < 70000; i++) begin
      rd(A_VAL, v);
      if (prev == 32'hFFFF) begin
        chk("R4 wrap from all ones", v, 0);
        seen = 1;
        break;
      end
      prev = v;
    end
    chk("R4 reached all ones", 32'(seen), 1);
    wr(A_CTRL, C_STOP);
    rd(A_STAT, v); chk("R4 no top flag with zero top", v & 4, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    t_reset();
    t_start_stop();
    t_trigger();
    t_div8();
    t_wrap();
    t_keep();
    t_mask();
    t_freerun();
    summary();
    $finish;
  end
endmodule